// File: doc/BRIEF.md
# Serial Management Master for Ethernet PHYs

This block lets a host manage Ethernet PHYs over the two-wire management bus (MDC clock, bidirectional MDIO data). The host sees five 32-bit registers on a simple single-cycle register port. A write to the command register sends one complete management frame. Short-preamble frames are not used: every frame is a 32-bit preamble of ones followed by 32 frame bits. The host then polls the status bits in the write-data or read-data register until the transfer is done, and collects any returned data.

The bus can run in either of two framing modes: the classic mode for links up to 1 Gb/s, or the extended-addressing mode. The MDC frequency is set by a divide count. The point inside each bit period at which returned data is latched can be tuned. While a read is returning data, the block releases MDIO through an output-enable pin. Clearing the enable register takes the bus down: any frame in progress is dropped and MDC stays low.

Register map: index 0 is clock/mode, 1 is command, 2 is write data, 3 is read data, 4 is enable. The clock/mode register holds the divide count in [7:0], the low sample-point nibble in [11:8], the high sample-point nibble in [19:16], and the extended-mode bit in [24]. Its reset value is 0x0000_0204. The command register holds the PHY address in [12:8], the register/device address in [4:0], and the opcode in [17:16]. Both data registers keep their 16 data bits in [15:0], the done flag in bit 16 and the busy flag in bit 17. The enable register uses bit 0. Register reads are combinational.

Top module: `mdio_master`

## Requirements
- R1: After reset, the clock/mode register reads 0x0000_0204 and the enable, write-data and read-data registers read 0. MDC is low and the MDIO output enable is low.
- R2: While the enable bit is 0, a command write sends no frame: MDC never rises and no busy flag is set.
- R3: With divide count D, MDC has a period of 2*(D+1) system clocks. Each bit starts with the low half, and MDIO changes only at the start of a bit.
- R4: In classic mode (mode bit 0), an opcode other than 2'b10 sends a write-direction frame. The frame is 32 ones, start 01, the opcode, the PHY address, the register address, turnaround 10, and the write-data register contents, all MSB first. The output enable stays high for all 64 bits.
- R5: In classic mode, opcode 2'b10 sends a read frame with start 01. The output enable is low from bit 46 (the turnaround) to the end. The 16 bits sampled in bits 48..63 appear MSB first in read-data [15:0].
- R6: A host read of the read-data register clears its done flag, and a host read of the write-data register clears its done flag. A read that arrives in the same cycle as a completion does not clear it.
- R7: In extended mode (mode bit 1), the start bits are 00. Opcodes 00 (address) and 01 (write) are write-direction and send the write-data register as the last 16 bits. Opcodes 11 (read) and 10 (read, post-increment) are reads.
- R8: A command write that arrives while either busy flag is set has no effect: the frame in progress is unchanged, no second frame follows, and the command register keeps the accepted command.
- R9: Read data is latched at the system clock whose in-bit phase index, counted from 0 at the start of the bit, equals the 8-bit sample point. A sample point above 2*(D+1)-1 behaves as 2*(D+1)-1.
- R10: The busy flag of the frame's direction is set from the cycle after the accepted command write until the frame ends. The done flag rises in the same cycle that busy falls, and the two directions are never busy at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears done flags) |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (high = master drives) |
| mdioIn | input | 1 | MDIO value seen on the bus |

## Verification
The hardest case to reach from the ports is the sample-point setting. A late sample point only changes which bus value is latched inside a bit, so it cannot be seen unless the responder's timing is pinned to the MDC edges. The bench's responder changes MDIO one nanosecond after each MDC rising edge. A sample point in the high half of the bit therefore latches the next bit's value, and the bench predicts the result as the PHY data shifted left by one, with the released bus (a one) filling the last place. A value above the bit length is used to check the clamp.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DATA_W     = 16;
  localparam int ADR_W      = 5;
  localparam int OP_W       = 2;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int REG_ADDR_W = 3;

  localparam int VAL_POS  = 16;
  localparam int PEND_POS = 17;
  localparam int OP_POS   = 16;
  localparam int PHY_POS  = 8;
  localparam int DEV_POS  = 0;
  localparam int SLO_POS  = 8;
  localparam int SHI_POS  = 16;
  localparam int MODE_POS = 24;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CLK  = 3'd0,
    REG_CMD  = 3'd1,
    REG_WDAT = 3'd2,
    REG_RDAT = 3'd3,
    REG_EN   = 3'd4
  } regSel_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
  } dpStrobe_t;

  typedef struct packed {
    logic              ext;
    logic [OP_W-1:0]   op;
    logic [ADR_W-1:0]  phy;
    logic [ADR_W-1:0]  dev;
    logic              isRead;
    logic [DATA_W-1:0] data;
  } frameReq_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int SAMP_W     = 8,
  parameter int BUS_W      = 32,
  parameter int RST_DIV    = 4,
  parameter int RST_SAMPLE = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWrData,
  output logic [BUS_W-1:0]      regRdData,
  input  logic [DATA_W-1:0]     rdCapture,
  output dpStrobe_t             strobe,
  output frameReq_t             frame,
  output logic                  mdc,
  output logic                  mdioOe,
  output logic                  enBit,
  output logic                  rdPend,
  output logic                  wrPend,
  output logic                  rdVal,
  output logic                  wrVal
);
  localparam int SAMP_HALF = SAMP_W / 2;
  localparam int PH_W      = DIV_W + 1;
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [SAMP_W-1:0] sampPt;
  logic              modeExt;
  logic              enReg;
  logic [DATA_W-1:0] wrData;
  logic [OP_W-1:0]   cmdOp;
  logic [ADR_W-1:0]  cmdPhy, cmdDev;
  logic              busy, isRead;
  logic [PH_W-1:0]   phaseCnt;
  logic [IDX_W-1:0]  bitIdx;

  logic [PH_W-1:0] lastPhase, sampEff;
  logic            launch, cmdIsRead, bitEnd, frameDone;
  logic [OP_W-1:0] newOp;

  assign lastPhase = {divCnt, 1'b1};
  always_comb begin
    if (32'(sampPt) > 32'(lastPhase)) sampEff = lastPhase;
    else                              sampEff = PH_W'(sampPt);
  end

  assign newOp     = regWrData[OP_POS +: OP_W];
  assign cmdIsRead = modeExt ? newOp[1] : (newOp == 2'b10);
  assign launch    = regWrEn && (regAddr == REG_CMD) && enReg && !busy;
  assign bitEnd    = busy && (phaseCnt == lastPhase);
  assign frameDone = bitEnd && (bitIdx == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= DIV_W'(RST_DIV);
      sampPt   <= SAMP_W'(RST_SAMPLE);
      modeExt  <= 1'b0;
      enReg    <= 1'b0;
      wrData   <= '0;
      cmdOp    <= '0;
      cmdPhy   <= '0;
      cmdDev   <= '0;
      busy     <= 1'b0;
      isRead   <= 1'b0;
      phaseCnt <= '0;
      bitIdx   <= '0;
      rdPend   <= 1'b0;
      wrPend   <= 1'b0;
      rdVal    <= 1'b0;
      wrVal    <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          REG_CLK: begin
            divCnt  <= regWrData[DIV_W-1:0];
            sampPt  <= {regWrData[SHI_POS +: SAMP_HALF], regWrData[SLO_POS +: SAMP_HALF]};
            modeExt <= regWrData[MODE_POS];
          end
          REG_WDAT: wrData <= regWrData[DATA_W-1:0];
          REG_EN:   enReg  <= regWrData[0];
          default: ;
        endcase
      end
      if (regRdEn && regAddr == REG_RDAT) rdVal <= 1'b0;
      if (regRdEn && regAddr == REG_WDAT) wrVal <= 1'b0;

      if (!enReg) begin
        busy     <= 1'b0;
        rdPend   <= 1'b0;
        wrPend   <= 1'b0;
        phaseCnt <= '0;
        bitIdx   <= '0;
      end else if (launch) begin
        busy     <= 1'b1;
        isRead   <= cmdIsRead;
        phaseCnt <= '0;
        bitIdx   <= '0;
        cmdOp    <= newOp;
        cmdPhy   <= regWrData[PHY_POS +: ADR_W];
        cmdDev   <= regWrData[DEV_POS +: ADR_W];
        if (cmdIsRead) begin
          rdPend <= 1'b1;
          rdVal  <= 1'b0;
        end else begin
          wrPend <= 1'b1;
          wrVal  <= 1'b0;
        end
      end else if (busy) begin
        if (bitEnd) begin
          phaseCnt <= '0;
          if (frameDone) begin
            busy <= 1'b0;
            if (isRead) begin
              rdPend <= 1'b0;
              rdVal  <= 1'b1;
            end else begin
              wrPend <= 1'b0;
              wrVal  <= 1'b1;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  // Bus pins: MDC low half first; bus released from turnaround on reads.
  assign mdc    = enReg && busy && (phaseCnt > PH_W'(divCnt));
  assign mdioOe = enReg && busy && !(isRead && (32'(bitIdx) >= TA_POS));
  assign enBit  = enReg;

  always_comb begin
    strobe.load   = launch;
    strobe.shift  = bitEnd;
    strobe.sample = busy && isRead && (32'(bitIdx) >= DATA_POS) && (phaseCnt == sampEff);
    frame.ext     = modeExt;
    frame.op      = newOp;
    frame.phy     = regWrData[PHY_POS +: ADR_W];
    frame.dev     = regWrData[DEV_POS +: ADR_W];
    frame.isRead  = cmdIsRead;
    frame.data    = wrData;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CLK: begin
        regRdData[DIV_W-1:0]             = divCnt;
        regRdData[SLO_POS +: SAMP_HALF]  = sampPt[SAMP_HALF-1:0];
        regRdData[SHI_POS +: SAMP_HALF]  = sampPt[SAMP_W-1:SAMP_HALF];
        regRdData[MODE_POS]              = modeExt;
      end
      REG_CMD: begin
        regRdData[OP_POS +: OP_W]   = cmdOp;
        regRdData[PHY_POS +: ADR_W] = cmdPhy;
        regRdData[DEV_POS +: ADR_W] = cmdDev;
      end
      REG_WDAT: begin
        regRdData[DATA_W-1:0] = wrData;
        regRdData[VAL_POS]    = wrVal;
        regRdData[PEND_POS]   = wrPend;
      end
      REG_RDAT: begin
        regRdData[DATA_W-1:0] = rdCapture;
        regRdData[VAL_POS]    = rdVal;
        regRdData[PEND_POS]   = rdPend;
      end
      REG_EN:  regRdData[0] = enReg;
      default: ;
    endcase
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  frameReq_t         frame,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdCapture
);
  logic [FRAME_LEN-1:0] shReg;
  logic [FRAME_LEN-1:0] frameWord;
  logic [1:0]           startBits, taBits;
  logic [DATA_W-1:0]    tailBits;

  always_comb begin
    startBits = frame.ext ? 2'b00 : 2'b01;
    taBits    = frame.isRead ? 2'b11 : 2'b10;
    tailBits  = frame.isRead ? '1 : frame.data;
    frameWord = {{PRE_LEN{1'b1}}, startBits, frame.op, frame.phy, frame.dev, taBits, tailBits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '1;
      rdCapture <= '0;
    end else begin
      if (strobe.load)       shReg <= frameWord;
      else if (strobe.shift) shReg <= {shReg[FRAME_LEN-2:0], 1'b1};
      if (strobe.sample)     rdCapture <= {rdCapture[DATA_W-2:0], mdioIn};
    end
  end

  assign mdioOut = shReg[FRAME_LEN-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int SAMP_W     = 8,
  parameter int BUS_W      = 32,
  parameter int RST_DIV    = 4,
  parameter int RST_SAMPLE = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]      regWrData,
  output logic [BUS_W-1:0]      regRdData,
  output logic                  mdc,
  output logic                  mdioOut,
  output logic                  mdioOe,
  input  logic                  mdioIn
);
  dpStrobe_t         strobe;
  frameReq_t         frame;
  logic [DATA_W-1:0] rdCapture;
  logic              enBit, rdPend, wrPend, rdVal, wrVal;

  mdio_ctrl #(
    .DIV_W(DIV_W), .SAMP_W(SAMP_W), .BUS_W(BUS_W),
    .RST_DIV(RST_DIV), .RST_SAMPLE(RST_SAMPLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rdCapture(rdCapture), .strobe(strobe), .frame(frame),
    .mdc(mdc), .mdioOe(mdioOe), .enBit(enBit),
    .rdPend(rdPend), .wrPend(wrPend), .rdVal(rdVal), .wrVal(wrVal)
  );

  mdio_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frame(frame),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .rdCapture(rdCapture)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  mdc,
  input logic                  mdioOe,
  input logic                  enBit,
  input logic                  rdPend,
  input logic                  wrPend,
  input logic                  rdVal,
  input logic                  regRdEn,
  input logic [REG_ADDR_W-1:0] regAddr
);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> (!mdc && !mdioOe));

  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPend && wrPend));

  a_r10_done_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && $fell(rdPend)) |-> rdVal);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == REG_RDAT && !rdPend) |=> !rdVal);

  a_r4_drive_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> (rdPend || wrPend));

  a_r3_mdc_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> (rdPend || wrPend));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOe(mdioOe), .enBit(enBit),
  .rdPend(rdPend), .wrPend(wrPend), .rdVal(rdVal),
  .regRdEn(regRdEn), .regAddr(regAddr)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int CLK_NS = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0, nFails = 0;

  // behavioural PHY state
  int          phyBit = 64;
  logic        phyRead = 1'b0;
  logic [15:0] phyData = '0;
  logic [63:0] capBits = '0, capOe = '0;
  longint      t0 = 0, t1 = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    int nb;
    if (phyBit < 64) begin
      capBits[63-phyBit] = mdioOut;
      capOe[63-phyBit]   = mdioOe;
      if (phyBit == 0) t0 = $time;
      if (phyBit == 1) t1 = $time;
      nb = phyBit + 1;
      phyBit = phyBit + 1;
      #1;
      if (phyRead && nb == 47)                 mdioIn = 1'b0;
      else if (phyRead && nb >= 48 && nb < 64) mdioIn = phyData[63-nb];
      else                                     mdioIn = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pollDone(input logic [2:0] a, output logic [31:0] d);
    for (int i = 0; i < 5000; i++) begin
      regRead(a, d);
      if (d[16] && !d[17]) break;
    end
  endtask

  task automatic armPhy(input logic rd, input logic [15:0] dat);
    phyBit = 0; phyRead = rd; phyData = dat; mdioIn = 1'b1;
  endtask

  function automatic logic [31:0] cmdWord(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] dev);
    return {14'b0, op, 3'b0, phy, 3'b0, dev};
  endfunction

  function automatic logic [31:0] clkWord(input logic ext, input logic [7:0] samp, input logic [7:0] dv);
    return {7'b0, ext, 4'b0, samp[7:4], 4'b0, samp[3:0], dv};
  endfunction

  function automatic logic [63:0] expFrame(input logic ext, input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] dev, input logic [15:0] dat);
    return {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, phy, dev, 2'b10, dat};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    regRead(3'd0, v); check(v == 32'h0000_0204, "R1 clock reg", 64'(v), 64'h204);
    regRead(3'd4, v); check(v == 0, "R1 enable reg", 64'(v), 0);
    regRead(3'd2, v); check(v == 0, "R1 wdata reg", 64'(v), 0);
    regRead(3'd3, v); check(v == 0, "R1 rdata reg", 64'(v), 0);
    check(!mdc && !mdioOe, "R1 pins idle", {62'b0, mdc, mdioOe}, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    armPhy(1'b0, 16'h0);
    regWrite(3'd2, 32'h0000_BEEF);
    regWrite(3'd1, cmdWord(2'b01, 5'h01, 5'h02));
    repeat (100) @(negedge clk);
    check(phyBit == 0, "R2 no MDC edge while off", 64'(phyBit), 0);
    regRead(3'd2, v);
    check(v[17:16] == 2'b00, "R2 no busy while off", 64'(v[17:16]), 0);
    phyBit = 64;
  endtask

  task automatic t_c22_write();
    logic [31:0] v;
    logic [63:0] e;
    regWrite(3'd0, clkWord(1'b0, 8'd1, 8'd1));
    regWrite(3'd2, 32'h0000_A5C3);
    armPhy(1'b0, 16'h0);
    regWrite(3'd1, cmdWord(2'b01, 5'h13, 5'h0A));
    regRead(3'd2, v);
    check(v[17] == 1'b1 && v[16] == 1'b0, "R10 write busy after launch", 64'(v[17:16]), 2'b10);
    pollDone(3'd2, v);
    check(v[17:16] == 2'b01, "R10 write done", 64'(v[17:16]), 2'b01);
    e = expFrame(1'b0, 2'b01, 5'h13, 5'h0A, 16'hA5C3);
    check(capBits == e, "R4 classic write frame", capBits, e);
    check(capOe == '1, "R4 driven all bits", capOe, '1);
    check((t1 - t0) == 4*CLK_NS, "R3 MDC period D=1", 64'(t1 - t0), 4*CLK_NS);
    regRead(3'd2, v);
    check(v[16] == 1'b0, "R6 wdata done cleared", 64'(v[16]), 0);
  endtask

  task automatic t_c22_read();
    logic [31:0] v;
    logic [63:0] e;
    regWrite(3'd0, clkWord(1'b0, 8'd1, 8'd2));
    armPhy(1'b1, 16'h3C96);
    regWrite(3'd1, cmdWord(2'b10, 5'h07, 5'h11));
    regRead(3'd3, v);
    check(v[17] == 1'b1, "R10 read busy after launch", 64'(v[17]), 1);
    pollDone(3'd3, v);
    e = expFrame(1'b0, 2'b10, 5'h07, 5'h11, 16'h0);
    check(capBits[63:18] == e[63:18], "R5 classic read header", 64'(capBits[63:18]), 64'(e[63:18]));
    check(capOe[17:0] == 0 && capOe[63:18] == '1, "R5 bus released from turnaround", capOe, {46'h3FFF_FFFF_FFFF, 18'h0});
    check(v[15:0] == 16'h3C96, "R5 read data", 64'(v[15:0]), 64'h3C96);
    check((t1 - t0) == 6*CLK_NS, "R3 MDC period D=2", 64'(t1 - t0), 6*CLK_NS);
    regRead(3'd3, v);
    check(v[16] == 1'b0, "R6 rdata done cleared", 64'(v[16]), 0);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    logic [63:0] e;
    regWrite(3'd0, clkWord(1'b1, 8'd0, 8'd1));
    regWrite(3'd2, 32'h0000_1234);
    armPhy(1'b0, 16'h0);
    regWrite(3'd1, cmdWord(2'b00, 5'h03, 5'h1E));
    pollDone(3'd2, v);
    e = expFrame(1'b1, 2'b00, 5'h03, 5'h1E, 16'h1234);
    check(capBits == e, "R7 extended address frame", capBits, e);
    armPhy(1'b1, 16'h5AF0);
    regWrite(3'd1, cmdWord(2'b11, 5'h03, 5'h1E));
    pollDone(3'd3, v);
    e = expFrame(1'b1, 2'b11, 5'h03, 5'h1E, 16'h0);
    check(capBits[63:18] == e[63:18] && capOe[17:0] == 0, "R7 extended read header", 64'(capBits[63:18]), 64'(e[63:18]));
    check(v[15:0] == 16'h5AF0, "R7 extended read data", 64'(v[15:0]), 64'h5AF0);
    armPhy(1'b1, 16'h0F0F);
    regWrite(3'd1, cmdWord(2'b10, 5'h04, 5'h01));
    pollDone(3'd3, v);
    check(v[15:0] == 16'h0F0F && capOe[17:0] == 0, "R7 post-increment read", 64'(v[15:0]), 64'h0F0F);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    logic [63:0] e;
    regWrite(3'd0, clkWord(1'b0, 8'd1, 8'd1));
    regWrite(3'd2, 32'h0000_C0DE);
    armPhy(1'b0, 16'h0);
    regWrite(3'd1, cmdWord(2'b01, 5'h09, 5'h05));
    regWrite(3'd1, cmdWord(2'b10, 5'h1F, 5'h1F));
    pollDone(3'd2, v);
    e = expFrame(1'b0, 2'b01, 5'h09, 5'h05, 16'hC0DE);
    check(capBits == e, "R8 frame unchanged by late command", capBits, e);
    repeat (100) @(negedge clk);
    check(phyBit == 64, "R8 no second frame", 64'(phyBit), 64);
    regRead(3'd3, v);
    check(v[17:16] == 2'b00, "R8 no read started", 64'(v[17:16]), 0);
    regRead(3'd1, v);
    check(v == cmdWord(2'b01, 5'h09, 5'h05), "R8 command reg keeps accepted", 64'(v), 64'(cmdWord(2'b01, 5'h09, 5'h05)));
  endtask

  task automatic t_sample();
    logic [31:0] v;
    // D=2: bit period 6, high half starts at phase 3
    regWrite(3'd0, clkWord(1'b0, 8'd0, 8'd2));
    armPhy(1'b1, 16'h9A61);
    regWrite(3'd1, cmdWord(2'b10, 5'h02, 5'h03));
    pollDone(3'd3, v);
    check(v[15:0] == 16'h9A61, "R9 early sample point", 64'(v[15:0]), 64'h9A61);
    regWrite(3'd0, clkWord(1'b0, 8'd4, 8'd2));
    armPhy(1'b1, 16'h9A61);
    regWrite(3'd1, cmdWord(2'b10, 5'h02, 5'h03));
    pollDone(3'd3, v);
    check(v[15:0] == 16'h34C3, "R9 late sample point", 64'(v[15:0]), 64'h34C3);
    regWrite(3'd0, clkWord(1'b0, 8'd200, 8'd2));
    armPhy(1'b1, 16'h9A61);
    regWrite(3'd1, cmdWord(2'b10, 5'h02, 5'h03));
    pollDone(3'd3, v);
    check(v[15:0] == 16'h34C3, "R9 clamped sample point", 64'(v[15:0]), 64'h34C3);
    regRead(3'd0, v);
    check(v == clkWord(1'b0, 8'd200, 8'd2), "R9 sample nibbles readback", 64'(v), 64'(clkWord(1'b0, 8'd200, 8'd2)));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_disabled();
    regWrite(3'd4, 32'h1);
    t_c22_write();
    t_c22_read();
    t_ext();
    t_busy_ignore();
    t_sample();
    finishRun();
  end
endmodule